// File: doc/BRIEF.md
# Requantizing Cancellation Datapath

This block is the digital path that builds the code for a charge-cancellation DAC in a fractional-N synthesizer. Once per reference period the fractional divider modulator hands over its negated quantization error. That is a wide signed word with 14 fractional bits, and it is qualified by a one-cycle strobe. Without further processing this word would need a DAC of about 15 bits.

A third-order error-feedback delta-sigma stage reduces the word to an 8-bit two's-complement code with 6 fractional bits, so one code step is 1/64. The stage has unity signal gain and no sample delay: the code for sample n is formed from sample n itself. The truncation error is pushed to high frequencies by the shaping (1 - z^-1)^3. The coarse codes are summed in an accumulator, and the running sum is the code presented to the cancellation DAC.

Because the requantizer adds no sample delay, the divider's division-ratio path needs no matching delay. The only latency is one register stage that is common to both outputs. Dither belongs to the divider modulator and is not applied anywhere in this path.

Top module: `qerr_requant_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `reqCode` and `dacCode` are 0 and `outValid` is 0. The three stored truncation residues are also cleared, so the first sample after reset sees zero feedback.
- R2: Let x be `errIn` in units of 2^-14, and let r1, r2, r3 be the residues of the previous three accepted samples. The stage computes v = x + 3*r1 - 3*r2 + r3. It outputs q = floor(v / 256) in units of 2^-6, and stores r = v - 256*q, which always lies in [0, 255].
- R3: A sample accepted with `inValid` high at a clock edge produces its own code, with no sample delay. `reqCode`, `dacCode` and a one-cycle `outValid` pulse appear together right after that edge.
- R4: For every input with |x| <= 24576 (±1.5), q lies within the signed 8-bit range [-128, 127]. The quantizer is never clipped.
- R5: `dacCode` equals the two's-complement sum of every `reqCode` value produced since reset.
- R6: After every accepted sample, 256*`dacCode` minus the running sum of all accepted x lies strictly between -512 and +512.
- R7: When every partial sum of accepted inputs stays within ±65536 (±4.0), the 10-bit `dacCode` accumulator never wraps.
- R8: When `inValid` is low, `errIn` is ignored. `reqCode`, `dacCode` and the residues hold, and `outValid` is 0.
- R9: `reqCode` is signed 8-bit with weight 2^-6, and `dacCode` is signed 10-bit with the same weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `errIn` for one cycle per reference period |
| errIn | input | 16 | Negated quantization error, signed, 14 fractional bits |
| outValid | output | 1 | One-cycle pulse marking fresh outputs |
| reqCode | output | 8 | Requantized sample, signed, 6 fractional bits |
| dacCode | output | 10 | Running sum of requantized samples, signed, 6 fractional bits |

## Verification
The bench sweeps alternating ±a inputs over the full legal amplitude, up to the ±1.5 limit where the quantizer sits closest to clipping. A stage with wrong feedback coefficients, the wrong sign on a residue, or round-to-nearest in place of floor would miss the exact per-sample code. Pseudo-random differenced sequences test the bounded gap between the accumulated code and the exact input sum; an accumulator that drops or repeats a sample would drift outside that window. Idle cycles carrying garbage on `errIn` are inserted between samples, and a reset is applied mid-stream. A design that latches unqualified input, or keeps residues across reset, would then produce the wrong next code.

// File: rtl/qerr_requant_pkg.sv
package qerr_requant_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic step;   // accept one sample this cycle
    logic clear;  // return all state to zero
  } dpCtl_t;

endpackage

// File: rtl/qerr_requant_ctrl.sv
module qerr_requant_ctrl
  import qerr_requant_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inValid,
  output dpCtl_t ctl,
  output logic   outValid
);

  always_comb begin
    ctl.clear = rst;
    ctl.step  = inValid & ~rst;
  end

  // Outputs are registered once, so the valid flag trails the strobe by one edge.
  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/qerr_requant_core.sv
module qerr_requant_core
  import qerr_requant_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 14,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 6,
  parameter int ACC_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpCtl_t                  ctl,
  input  logic signed [IN_W-1:0]  errIn,
  output logic signed [OUT_W-1:0] reqCode,
  output logic signed [ACC_W-1:0] dacCode
);

  localparam int DROP  = IN_FRAC - OUT_FRAC;  // low bits removed by the quantizer
  localparam int ORDER = 3;
  localparam int SUM_W = IN_W + 3;            // headroom for the residue feedback
  localparam int Q_W   = SUM_W - DROP;

  logic [DROP-1:0] resid [ORDER];             // resid[0] belongs to the newest sample

  logic signed [SUM_W-1:0] xExt, t1, t2, t3, vSum;
  logic signed [Q_W-1:0]   qWide;
  logic [DROP-1:0]         residNew;
  logic signed [OUT_W-1:0] reqNext;
  logic signed [ACC_W:0]   accSum;

  // Error feedback with NTF (1 - z^-1)^3. Floor truncation keeps the residue non-negative.
  always_comb begin
    xExt     = {{(SUM_W-IN_W){errIn[IN_W-1]}}, errIn};
    t1       = $signed({{(SUM_W-DROP){1'b0}}, resid[0]});
    t2       = $signed({{(SUM_W-DROP){1'b0}}, resid[1]});
    t3       = $signed({{(SUM_W-DROP){1'b0}}, resid[2]});
    vSum     = xExt + (t1 <<< 1) + t1 - (t2 <<< 1) - t2 + t3;
    qWide    = vSum[SUM_W-1:DROP];
    residNew = vSum[DROP-1:0];
    reqNext  = qWide[OUT_W-1:0];
    accSum   = {dacCode[ACC_W-1], dacCode}
             + {{(ACC_W+1-OUT_W){reqNext[OUT_W-1]}}, reqNext};
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      for (int k = 0; k < ORDER; k++) resid[k] <= '0;
      reqCode <= '0;
      dacCode <= '0;
    end else if (ctl.step) begin
      resid[0] <= residNew;
      for (int k = 1; k < ORDER; k++) resid[k] <= resid[k-1];
      reqCode <= reqNext;
      dacCode <= accSum[ACC_W-1:0];
    end
  end

  // R4: the wide quotient must fit the output word, so the quantizer is never clipped.
  assert_no_overload_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.step |-> (qWide[Q_W-1:OUT_W-1] == '0 || qWide[Q_W-1:OUT_W-1] == '1));

  // R7: the accumulator must not wrap on legal sequences.
  assert_acc_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.step |-> (accSum[ACC_W] == accSum[ACC_W-1]));

  // R8: with no accepted sample, the outputs hold.
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.step |=> ($stable(reqCode) && $stable(dacCode)));

  // R1: outputs are zero on the first cycle after reset falls.
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reqCode == '0 && dacCode == '0));

endmodule

// File: rtl/qerr_requant_top.sv
module qerr_requant_top
  import qerr_requant_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 14,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 6,
  parameter int ACC_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  errIn,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] reqCode,
  output logic signed [ACC_W-1:0] dacCode
);

  dpCtl_t ctl;

  qerr_requant_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  qerr_requant_core #(
    .IN_W     (IN_W),
    .IN_FRAC  (IN_FRAC),
    .OUT_W    (OUT_W),
    .OUT_FRAC (OUT_FRAC),
    .ACC_W    (ACC_W)
  ) core_i (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .errIn   (errIn),
    .reqCode (reqCode),
    .dacCode (dacCode)
  );

endmodule

// File: tb/qerr_requant_tb.sv
`timescale 1ns/1ps
module qerr_requant_top_tb_top;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic signed [15:0] errIn = '0;
  logic              outValid;
  logic signed [7:0] reqCode;
  logic signed [9:0] dacCode;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 0;

  // Bench model state, taken from the R2 equation.
  int r1 = 0, r2 = 0, r3 = 0;
  int accModel = 0;
  int sumX = 0;
  int lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  qerr_requant_top dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .errIn(errIn),
    .outValid(outValid), .reqCode(reqCode), .dacCode(dacCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    r1 = 0; r2 = 0; r3 = 0; accModel = 0; sumX = 0;
  endtask

  // Drive one sample at a falling edge; check on the next falling edge.
  task automatic doSample(input int x);
    int v, q, d;
    errIn = 16'(x);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    v = x + 3*r1 - 3*r2 + r3;
    q = v >>> 8;
    r3 = r2; r2 = r1; r1 = v - q*256;
    accModel += q;
    sumX += x;
    check(outValid == 1'b1, "R3 outValid", int'(outValid), 1);
    check(int'(reqCode) == q, "R2 reqCode", int'(reqCode), q);
    check(q >= -128 && q <= 127, "R4 range", q, 0);
    check(int'(dacCode) == accModel, "R5 dacCode", int'(dacCode), accModel);
    d = 256*int'(dacCode) - sumX;
    check(d > -512 && d < 512, "R6 window", d, 0);
  endtask

  task automatic doIdle(input int garbage);
    logic signed [7:0] rq;
    logic signed [9:0] dc;
    rq = reqCode; dc = dacCode;
    errIn = 16'(garbage);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8 outValid idle", int'(outValid), 0);
    check(reqCode == rq && dacCode == dc, "R8 hold", int'(dacCode), int'(dc));
  endtask

  function automatic int nextU();
    lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
    return (lfsr % 24577) - 12288;  // within +-0.75
  endfunction

  task automatic applyReset();
    rst = 1'b1;
    inValid = 1'b1;
    errIn = 16'sd9000;  // must be ignored during reset
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(reqCode == 0 && dacCode == 0, "R1 outputs", int'(dacCode), 0);
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    check(reqCode == 0 && dacCode == 0 && outValid == 0, "R1 after release", int'(dacCode), 0);
    modelReset();
  endtask

  initial begin
    int uPrev, u;
    @(negedge clk);
    applyReset();

    // Zero input: code stays zero (R2, R9).
    for (int i = 0; i < 8; i++) doSample(0);
    check(dacCode == 0, "R9 zero acc", int'(dacCode), 0);

    // Alternating +-a amplitude sweep up to the +-1.5 limit (R4, R6, R7).
    for (int a = 0; a <= 24576; a += 256) begin
      for (int k = 0; k < 4; k++) begin
        doSample(a);
        doSample(-a);
      end
    end
    for (int k = 0; k < 16; k++) begin
      doSample(24576);
      doSample(-24576);
    end

    // Idle cycles with garbage between samples (R8).
    for (int k = 0; k < 20; k++) begin
      doSample(1000 + 37*k);
      doIdle(-20000 + 911*k);
      doIdle(31000);
      doSample(-(1000 + 37*k));
    end

    // Mid-stream reset, then differenced pseudo-random input (R1, R6).
    applyReset();
    uPrev = 0;
    for (int n = 0; n < 800; n++) begin
      u = nextU();
      doSample(u - uPrev);
      uPrev = u;
    end

    // Large positive excursion of the running sum, near +4.0 (R7).
    applyReset();
    for (int k = 0; k < 3; k++) doSample(21000);
    for (int k = 0; k < 3; k++) doSample(-21000);
    check(int'(dacCode) == accModel, "R7 excursion", int'(dacCode), accModel);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule